// File: doc/BRIEF.md
# Debug Abstract Command Engine

This block sits between a debugger-facing register port and the harts of a multi-hart core. The debugger writes a 32-bit abstract command; the engine checks it, and for a register-access command it writes a short RV32/RV64 instruction sequence into a small abstract-program memory. That sequence moves a value between a data word and an integer register, a floating-point register or a CSR. The engine then raises the go flag of the selected hart and marks itself busy. The halted hart fetches the sequence through a read port. The sequence ends either in an ebreak or in a jump into the program buffer, which the debugger fills and which always ends with one extra ebreak word.

Errors are held in a sticky three-bit code that the debugger clears by writing ones. Auto-execute masks let an access to data word i or program-buffer word i replay the last command without writing the command register again. Hart-side pulses report that the hart has halted, that it has left the park loop (going), and that the sequence took an exception.

Top module: `dbg_cmd_engine`

## Requirements
- R1: The command register is at address 0x22. Its fields are type [31:24], size [22:20], post-execute bit 18, transfer bit 17, write bit 16 and register number [15:0]. Bits 23 and 19 are reserved. A non-zero type, or a reserved bit that is set, gives error code 2 (not supported).
- R2: While the error code is non-zero, a new command is dropped: busy stays low and the code does not change. A command issued while busy sets code 1 (busy) if the code was 0.
- R3: If the selected hart is not halted, a command gives code 4, leaves its go flag clear and does not raise busy.
- R4: A transfer to register numbers below 0x1000 (CSRs) builds five words. Word 0 is csrrw x0,dscratch,s0. For a write, words 1 and 2 are a load of s0 from the data address and csrrw x0,csr,s0. For a read, they are csrrs s0,csr,x0 and a store of s0 to the data address. Word 3 is csrrs s0,dscratch,x0 and word 4 is the final word.
- R5: Numbers 0x1000–0x101F use one integer load (write) or store (read) of x(n−0x1000). Numbers 0x1020–0x103F use the floating-point equivalent. Both use base x0 and the data-address immediate, and are followed by the final word. Any higher number gives code 2.
- R6: With transfer set, size 2 selects word accesses (funct3 010) and size 3 selects doubleword accesses (funct3 011). Any other size gives code 2. Without transfer, the size is not checked.
- R7: The final word is jal x0 to the program-buffer start (offset 4·(5−index)) when post-execute is set, and ebreak (0x00100073) otherwise. The cycle after the launching write, busy is high and the go flag of the selected hart is set.
- R8: A going pulse clears the go flag of the selected hart. Busy clears on a halted pulse whose hart id equals the selected hart and whose go flag is already clear.
- R9: The status register at 0x20 holds the error code in bits [2:0] and busy in bit 4. Writing ones to bits [2:0] clears the matching error bits.
- R10: An exception pulse sets code 3 only when the code is 0.
- R11: Data word i is at address 0x00+i and program-buffer word i at 0x10+i. While busy, reads of them return 0xFFFFFFFF and writes to them are dropped. A data access while busy also sets code 1 if the code was 0.
- R12: The mask register at 0x21 holds the data mask in bits [15:0] and the program-buffer mask in bits [31:16]. When not busy, an access to word i whose mask bit i is set re-runs the stored command.
- R13: The hart read port of the program buffer returns the stored words, and at index PB_WORDS it returns ebreak.
- R14: After reset the error code, busy, all go flags and the response are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | 32 | Read data |
| hart_sel | input | 2 | Selected hart |
| hart_halted | input | 4 | Halted state of each hart |
| halt_evt | input | 1 | Pulse: hart halt_id entered the park loop |
| halt_id | input | 2 | Hart that raised halt_evt |
| going_evt | input | 1 | Pulse: the selected hart took its go flag |
| exc_evt | input | 1 | Pulse: the abstract sequence took an exception |
| go_flags | output | 4 | Go flag of each hart |
| busy | output | 1 | A command is running |
| cmd_err | output | 3 | Sticky error code |
| abs_raddr | input | 3 | Abstract-program read index |
| abs_rdata | output | 32 | Abstract-program word (registered) |
| pb_raddr | input | 3 | Program-buffer read index for the hart |
| pb_rdata | output | 32 | Program-buffer word (registered) |

## Verification
Directed commands cover each register class: a CSR read and a CSR write, an integer write with post-execute, and a floating-point read. This separates the five-word CSR path from the single-access path, and the jump offset from the ebreak ending. Corner cases cover every error source one at a time: bad type, reserved bit, bad size, out-of-range number, hart not running, busy and exception. They show which error wins and that the sticky code blocks later commands. A seeded random stream of commands then mixes the register-number ranges, sizes, direction and post-execute bits. Each result is compared with an instruction encoder written inside the bench.

// File: rtl/dce_pkg.sv
package dce_pkg;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_BUSY   = 3'd1,
    ERR_NOTSUP = 3'd2,
    ERR_EXC    = 3'd3,
    ERR_HALT   = 3'd4
  } err_e;

  typedef struct packed {
    logic [7:0]  kind;
    logic        rsv23;
    logic [2:0]  size;
    logic        rsv19;
    logic        post;
    logic        xfer;
    logic        wr;
    logic [15:0] regno;
  } acmd_t;

  localparam logic [6:0]  OP_LOAD    = 7'b0000011;
  localparam logic [6:0]  OP_LOADFP  = 7'b0000111;
  localparam logic [6:0]  OP_STORE   = 7'b0100011;
  localparam logic [6:0]  OP_STOREFP = 7'b0100111;
  localparam logic [6:0]  OP_SYSTEM  = 7'b1110011;
  localparam logic [6:0]  OP_JAL     = 7'b1101111;
  localparam logic [4:0]  REG_S0     = 5'd8;
  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2,
                                        logic [4:0] rs1, logic [2:0] f3, logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [31:0] enc_jal0(logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd0, OP_JAL};
  endfunction

  // csrrw x0, csr, s0
  function automatic logic [31:0] enc_csr_from_s0(logic [11:0] csr);
    return {csr, REG_S0, 3'b001, 5'd0, OP_SYSTEM};
  endfunction

  // csrrs s0, csr, x0
  function automatic logic [31:0] enc_csr_to_s0(logic [11:0] csr);
    return {csr, 5'd0, 3'b010, REG_S0, OP_SYSTEM};
  endfunction

endpackage

// File: rtl/dce_encode.sv
module dce_encode
  import dce_pkg::*;
#(
  parameter int          ABS_WORDS    = 5,   // must be at least 5 (CSR path)
  parameter logic [11:0] DATA_ADDR    = 12'h380,
  parameter logic [11:0] DSCRATCH_CSR = 12'h7b2
) (
  input  acmd_t                      cmd,
  input  logic                       hart_ok,
  output err_e                       err,
  output logic [ABS_WORDS-1:0][31:0] words
);

  logic       size_ok;
  logic [2:0] f3;
  logic [4:0] rn;
  int         fin;

  always_comb begin
    words   = '0;
    err     = ERR_NONE;
    fin     = 0;
    f3      = {2'b01, cmd.size[0]};
    size_ok = (cmd.size == 3'd2) || (cmd.size == 3'd3);
    rn      = cmd.regno[4:0];

    if (cmd.kind != 8'd0 || cmd.rsv23 || cmd.rsv19) begin
      err = ERR_NOTSUP;
    end else if (!hart_ok) begin
      err = ERR_HALT;
    end else if (cmd.xfer) begin
      if (!size_ok) begin
        err = ERR_NOTSUP;
      end else if (cmd.regno < 16'h1000) begin
        words[0] = enc_csr_from_s0(DSCRATCH_CSR);
        if (cmd.wr) begin
          words[1] = enc_i(DATA_ADDR, 5'd0, f3, REG_S0, OP_LOAD);
          words[2] = enc_csr_from_s0(cmd.regno[11:0]);
        end else begin
          words[1] = enc_csr_to_s0(cmd.regno[11:0]);
          words[2] = enc_s(DATA_ADDR, REG_S0, 5'd0, f3, OP_STORE);
        end
        words[3] = enc_csr_to_s0(DSCRATCH_CSR);
        fin = 4;
      end else if (cmd.regno < 16'h1040) begin
        // bit 5 separates the integer block from the floating-point block
        if (cmd.wr)
          words[0] = enc_i(DATA_ADDR, 5'd0, f3, rn, cmd.regno[5] ? OP_LOADFP : OP_LOAD);
        else
          words[0] = enc_s(DATA_ADDR, rn, 5'd0, f3, cmd.regno[5] ? OP_STOREFP : OP_STORE);
        fin = 1;
      end else begin
        err = ERR_NOTSUP;
      end
    end

    if (err == ERR_NONE) begin
      for (int k = 0; k < ABS_WORDS; k++) begin
        // program buffer starts right after the last abstract word
        if (k == fin)
          words[k] = cmd.post ? enc_jal0(21'(4 * (ABS_WORDS - k))) : INSN_EBREAK;
      end
    end
  end

endmodule

// File: rtl/dce_absmem.sv
module dce_absmem #(
  parameter int ABS_WORDS = 5,
  localparam int ABS_AW   = $clog2(ABS_WORDS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ABS_WORDS-1:0][31:0] wwords,
  input  logic [ABS_AW-1:0]          raddr,
  output logic [31:0]                rdata
);

  logic [ABS_WORDS-1:0][31:0] mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
      rdata <= '0;
    end else begin
      if (we) mem_q <= wwords;
      rdata <= (32'(raddr) < ABS_WORDS) ? mem_q[raddr] : 32'd0;
    end
  end

endmodule

// File: rtl/dce_pbuf.sv
module dce_pbuf #(
  parameter int PB_WORDS = 4,
  localparam int PIDX_W  = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1,
  localparam int PB_AW   = $clog2(PB_WORDS + 1)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PIDX_W-1:0] waddr,
  input  logic [31:0]       wdata,
  input  logic [PIDX_W-1:0] dbg_raddr,
  output logic [31:0]       dbg_rdata,
  input  logic [PB_AW-1:0]  hart_raddr,
  output logic [31:0]       hart_rdata
);

  logic [31:0] mem [PB_WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign dbg_rdata = mem[dbg_raddr];

  always_ff @(posedge clk) begin
    if (32'(hart_raddr) == PB_WORDS)
      hart_rdata <= dce_pkg::INSN_EBREAK;
    else if (32'(hart_raddr) < PB_WORDS)
      hart_rdata <= mem[hart_raddr[PIDX_W-1:0]];
    else
      hart_rdata <= '0;
  end

endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
  import dce_pkg::*;
#(
  parameter int          NHARTS       = 4,
  parameter int          DATA_WORDS   = 2,
  parameter int          PB_WORDS     = 4,
  parameter int          ABS_WORDS    = 5,
  parameter logic [11:0] DATA_ADDR    = 12'h380,
  parameter logic [11:0] DSCRATCH_CSR = 12'h7b2,
  parameter int          AW           = 8,
  localparam int HSEL_W = (NHARTS > 1) ? $clog2(NHARTS) : 1,
  localparam int ABS_AW = $clog2(ABS_WORDS),
  localparam int PB_AW  = $clog2(PB_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [HSEL_W-1:0] hart_sel,
  input  logic [NHARTS-1:0] hart_halted,
  input  logic              halt_evt,
  input  logic [HSEL_W-1:0] halt_id,
  input  logic              going_evt,
  input  logic              exc_evt,
  output logic [NHARTS-1:0] go_flags,
  output logic              busy,
  output logic [2:0]        cmd_err,
  input  logic [ABS_AW-1:0] abs_raddr,
  output logic [31:0]       abs_rdata,
  input  logic [PB_AW-1:0]  pb_raddr,
  output logic [31:0]       pb_rdata
);

  localparam int DIDX_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
  localparam int PIDX_W = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1;
  localparam logic [AW-1:0] A_PB   = AW'(8'h10);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h20);
  localparam logic [AW-1:0] A_AUTO = AW'(8'h21);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h22);

  // ---------------- state ----------------
  acmd_t                 cmd_q;
  logic                  busy_q, busy_n;
  err_e                  err_q, err_n;
  logic [NHARTS-1:0]     go_q, go_n;
  logic [DATA_WORDS-1:0] am_data_q;
  logic [PB_WORDS-1:0]   am_pb_q;
  logic [31:0]           data_q [DATA_WORDS];

  // ---------------- request decode ----------------
  logic              is_data, is_pb, rd_req, wr_req;
  logic [DIDX_W-1:0] d_idx;
  logic [PIDX_W-1:0] p_idx;
  logic              cmd_wr, auto_hit, trigger, launch;
  acmd_t             cmd_use;
  err_e              enc_err;
  logic [ABS_WORDS-1:0][31:0] enc_words;
  logic [31:0]       pb_dbg_rdata;
  logic [NHARTS-1:0] sel_oh;

  assign rd_req  = req_valid && !req_write;
  assign wr_req  = req_valid && req_write;
  assign is_data = req_addr < AW'(DATA_WORDS);
  assign is_pb   = (req_addr >= A_PB) && (req_addr < A_PB + AW'(PB_WORDS));
  assign d_idx   = req_addr[DIDX_W-1:0];
  assign p_idx   = req_addr[PIDX_W-1:0];
  assign sel_oh  = NHARTS'(1) << hart_sel;

  assign cmd_wr   = wr_req && (req_addr == A_CMD);
  assign auto_hit = req_valid && !busy_q &&
                    ((is_data && am_data_q[d_idx]) || (is_pb && am_pb_q[p_idx]));
  assign trigger  = cmd_wr || auto_hit;
  assign cmd_use  = cmd_wr ? acmd_t'(req_wdata) : cmd_q;
  assign launch   = trigger && (err_q == ERR_NONE) && !busy_q && (enc_err == ERR_NONE);

  dce_encode #(
    .ABS_WORDS   (ABS_WORDS),
    .DATA_ADDR   (DATA_ADDR),
    .DSCRATCH_CSR(DSCRATCH_CSR)
  ) u_enc (
    .cmd    (cmd_use),
    .hart_ok(hart_halted[hart_sel]),
    .err    (enc_err),
    .words  (enc_words)
  );

  dce_absmem #(.ABS_WORDS(ABS_WORDS)) u_abs (
    .clk   (clk),
    .rst   (rst),
    .we    (launch),
    .wwords(enc_words),
    .raddr (abs_raddr),
    .rdata (abs_rdata)
  );

  dce_pbuf #(.PB_WORDS(PB_WORDS)) u_pb (
    .clk       (clk),
    .we        (wr_req && is_pb && !busy_q),
    .waddr     (p_idx),
    .wdata     (req_wdata),
    .dbg_raddr (p_idx),
    .dbg_rdata (pb_dbg_rdata),
    .hart_raddr(pb_raddr),
    .hart_rdata(pb_rdata)
  );

  // ---------------- next state ----------------
  always_comb begin
    err_n = err_q;
    if (wr_req && req_addr == A_CTRL)
      err_n = err_e'(err_q & ~req_wdata[2:0]);
    if (req_valid && is_data && busy_q && err_n == ERR_NONE)
      err_n = ERR_BUSY;
    if (exc_evt && err_n == ERR_NONE)
      err_n = ERR_EXC;
    if (trigger && err_q == ERR_NONE && err_n == ERR_NONE) begin
      if (busy_q)                    err_n = ERR_BUSY;
      else if (enc_err != ERR_NONE)  err_n = enc_err;
    end
  end

  always_comb begin
    busy_n = busy_q;
    go_n   = go_q;
    if (halt_evt && halt_id == hart_sel && !go_q[halt_id])
      busy_n = 1'b0;
    if (going_evt)
      go_n[hart_sel] = 1'b0;
    if (launch) begin
      busy_n         = 1'b1;
      go_n[hart_sel] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      busy_q    <= 1'b0;
      err_q     <= ERR_NONE;
      go_q      <= '0;
      am_data_q <= '0;
      am_pb_q   <= '0;
      for (int i = 0; i < DATA_WORDS; i++) data_q[i] <= '0;
    end else begin
      busy_q <= busy_n;
      err_q  <= err_n;
      go_q   <= go_n;
      if (cmd_wr) cmd_q <= cmd_use;
      if (wr_req && req_addr == A_AUTO) begin
        am_data_q <= req_wdata[DATA_WORDS-1:0];
        am_pb_q   <= req_wdata[16 +: PB_WORDS];
      end
      if (wr_req && is_data && !busy_q) data_q[d_idx] <= req_wdata;
    end
  end

  // ---------------- read response ----------------
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (is_data)
      rd_mux = busy_q ? '1 : data_q[d_idx];
    else if (is_pb)
      rd_mux = busy_q ? '1 : pb_dbg_rdata;
    else if (req_addr == A_CTRL)
      rd_mux = {27'd0, busy_q, 1'b0, err_q};
    else if (req_addr == A_AUTO)
      rd_mux = {16'(am_pb_q), 16'(am_data_q)};
    else if (req_addr == A_CMD)
      rd_mux = cmd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_mux;
    end
  end

  assign go_flags = go_q;
  assign busy     = busy_q;
  assign cmd_err  = err_q;

  // ---------------- assertions ----------------
  assert_launch_go_R7: assert property (@(posedge clk) disable iff (rst)
    launch |=> (busy_q && ((go_q & $past(sel_oh)) != '0)));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err_q != ERR_NONE && !(wr_req && req_addr == A_CTRL)) |=> (err_q == $past(err_q)));

  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(halt_evt));

  assert_busy_ones_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (is_data || is_pb) && busy_q) |=> (rsp_rdata == 32'hFFFF_FFFF));

  assert_err_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    (trigger && err_q != ERR_NONE) |=> !$rose(busy_q));

  assert_exc_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (exc_evt && err_q == ERR_BUSY) |=> (err_q == ERR_BUSY));

endmodule

// File: tb/tb_dbg_cmd_engine.sv
module tb_dbg_cmd_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  hart_sel = 2'd0;
  logic [3:0]  hart_halted = 4'b1011;
  logic        halt_evt = 1'b0, going_evt = 1'b0, exc_evt = 1'b0;
  logic [1:0]  halt_id = 2'd0;
  logic [3:0]  go_flags;
  logic        busy;
  logic [2:0]  cmd_err;
  logic [2:0]  abs_raddr = '0;
  logic [31:0] abs_rdata;
  logic [2:0]  pb_raddr = '0;
  logic [31:0] pb_rdata;

  always #2 clk = ~clk;

  dbg_cmd_engine dut (.*);

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] ew [5];
  int ee;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------- independent instruction encoders ----------
  function automatic logic [31:0] b_ld(logic [4:0] rd, logic [2:0] f3, logic [6:0] op);
    logic [11:0] a = 12'h380;
    return {a, 5'd0, f3, rd, op};
  endfunction
  function automatic logic [31:0] b_st(logic [4:0] rs, logic [2:0] f3, logic [6:0] op);
    logic [11:0] a = 12'h380;
    return {a[11:5], rs, 5'd0, f3, a[4:0], op};
  endfunction
  function automatic logic [31:0] b_csrw(logic [11:0] c);
    return {c, 5'd8, 3'd1, 5'd0, 7'h73};
  endfunction
  function automatic logic [31:0] b_csrr(logic [11:0] c);
    return {c, 5'd0, 3'd2, 5'd8, 7'h73};
  endfunction
  function automatic logic [31:0] b_jal(int off);
    logic [20:0] o = off[20:0];
    return {o[20], o[10:1], o[11], o[19:12], 5'd0, 7'h6f};
  endfunction
  function automatic logic [31:0] mk(logic [7:0] kind, logic [2:0] sz, bit post,
                                     bit xf, bit w, logic [15:0] rg);
    return {kind, 1'b0, sz, 1'b0, post, xf, w, rg};
  endfunction

  task automatic model(input logic [31:0] c, input bit h);
    logic [2:0]  sz = c[22:20];
    logic [15:0] rg = c[15:0];
    logic [2:0]  f3 = (sz == 3'd3) ? 3'd3 : 3'd2;
    int fin = 0;
    for (int k = 0; k < 5; k++) ew[k] = '0;
    ee = 0;
    if (c[31:24] != 0 || c[23] || c[19]) ee = 2;
    else if (!h) ee = 4;
    else if (c[17]) begin
      if (sz != 3'd2 && sz != 3'd3) ee = 2;
      else if (rg < 16'h1000) begin
        ew[0] = b_csrw(12'h7b2);
        ew[1] = c[16] ? b_ld(5'd8, f3, 7'h03) : b_csrr(rg[11:0]);
        ew[2] = c[16] ? b_csrw(rg[11:0]) : b_st(5'd8, f3, 7'h23);
        ew[3] = b_csrr(12'h7b2);
        fin = 4;
      end else if (rg < 16'h1020) begin
        ew[0] = c[16] ? b_ld(5'(rg - 16'h1000), f3, 7'h03) : b_st(5'(rg - 16'h1000), f3, 7'h23);
        fin = 1;
      end else if (rg < 16'h1040) begin
        ew[0] = c[16] ? b_ld(5'(rg - 16'h1020), f3, 7'h07) : b_st(5'(rg - 16'h1020), f3, 7'h27);
        fin = 1;
      end else ee = 2;
    end
    if (ee == 0) ew[fin] = c[18] ? b_jal(4 * (5 - fin)) : 32'h0010_0073;
  endtask

  // ---------- port tasks ----------
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0; req_write = 0;
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0; d = rsp_rdata;
  endtask
  task automatic rd_abs(int k, output logic [31:0] d);
    @(negedge clk); abs_raddr = 3'(k);
    @(negedge clk); d = abs_rdata;
  endtask
  task automatic pulse_halt(logic [1:0] id);
    @(negedge clk); halt_evt = 1; halt_id = id;
    @(negedge clk); halt_evt = 0;
  endtask
  task automatic pulse_going();
    @(negedge clk); going_evt = 1;
    @(negedge clk); going_evt = 0;
  endtask
  task automatic pulse_exc();
    @(negedge clk); exc_evt = 1;
    @(negedge clk); exc_evt = 0;
  endtask
  task automatic recover();
    if (busy) begin pulse_going(); pulse_halt(hart_sel); end
    wr(8'h20, 32'h7);
  endtask

  task automatic run_cmd(string req, logic [31:0] c);
    logic [31:0] v;
    recover();
    model(c, hart_halted[hart_sel]);
    wr(8'h22, c);
    rd(8'h20, v);
    check(req, v, (ee == 0) ? 32'h10 : 32'(ee));
    check(req, 32'(go_flags), (ee == 0) ? 32'(4'b1 << hart_sel) : 32'd0);
    if (ee == 0)
      for (int k = 0; k < 5; k++) begin
        rd_abs(k, v);
        check(req, v, ew[k]);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R14 reset state
    check("R14", {busy, cmd_err, go_flags, rsp_valid}, 0);
    rd(8'h20, v);  check("R14", v, 0);

    // R11 data/pbuf access when idle
    wr(8'h00, 32'h1234_5678); wr(8'h01, 32'h9abc_def0);
    rd(8'h01, v); check("R11", v, 32'h9abc_def0);

    // R4 CSR read
    run_cmd("R4", mk(8'd0, 3'd2, 0, 1, 0, 16'h0300));
    // R2 command while busy
    wr(8'h22, mk(8'd0, 3'd2, 0, 1, 0, 16'h0300));
    rd(8'h20, v); check("R2", v, 32'h11);
    // R11 reads while busy, write dropped
    rd(8'h00, v); check("R11", v, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R11", v, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_dead);
    wr(8'h20, 32'h1); rd(8'h20, v); check("R9", v, 32'h10);
    rd(8'h01, v); rd(8'h20, v); check("R11", v, 32'h11);
    // R8 busy / go handshake
    pulse_halt(2'd0); check("R8", 32'(busy), 1);
    pulse_going();    check("R8", 32'(go_flags), 0);
    pulse_halt(2'd1); check("R8", 32'(busy), 1);
    pulse_halt(2'd0); check("R8", 32'(busy), 0);
    wr(8'h20, 32'h7);
    rd(8'h00, v); check("R11", v, 32'h1234_5678);

    // R1 bad type, reserved bit; R2 sticky error
    run_cmd("R1", mk(8'd1, 3'd2, 0, 1, 0, 16'h0300));
    run_cmd("R1", mk(8'd0, 3'd2, 0, 1, 0, 16'h1001) | 32'h0080_0000);
    wr(8'h22, mk(8'd0, 3'd2, 0, 1, 0, 16'h1001));
    rd(8'h20, v); check("R2", v, 32'h2);
    wr(8'h20, 32'h1); rd(8'h20, v); check("R9", v, 32'h2);
    wr(8'h20, 32'h2); rd(8'h20, v); check("R9", v, 32'h0);

    // R3 hart not halted
    hart_sel = 2'd2;
    run_cmd("R3", mk(8'd0, 3'd2, 0, 1, 0, 16'h1001));
    hart_sel = 2'd0;

    // R6 sizes
    run_cmd("R6", mk(8'd0, 3'd4, 0, 1, 1, 16'h1001));
    run_cmd("R6", mk(8'd0, 3'd4, 0, 0, 1, 16'h1001));
    run_cmd("R6", mk(8'd0, 3'd3, 0, 1, 0, 16'h0f14));
    // R5 ranges
    run_cmd("R5", mk(8'd0, 3'd2, 0, 1, 0, 16'h1040));
    run_cmd("R5", mk(8'd0, 3'd3, 1, 1, 1, 16'h1005));
    run_cmd("R5", mk(8'd0, 3'd2, 0, 1, 0, 16'h1023));
    run_cmd("R5", mk(8'd0, 3'd2, 1, 1, 1, 16'h103f));
    // R7 CSR write with post-execute, and plain ebreak
    run_cmd("R7", mk(8'd0, 3'd3, 1, 1, 1, 16'h07b0));
    run_cmd("R7", mk(8'd0, 3'd2, 1, 0, 0, 16'h0000));

    // R10 exception
    recover();
    pulse_exc(); rd(8'h20, v); check("R10", v, 32'h3);
    wr(8'h20, 32'h7);
    run_cmd("R10", mk(8'd0, 3'd2, 0, 1, 0, 16'h1001));
    wr(8'h22, 32'h0); pulse_exc();
    rd(8'h20, v); check("R10", v, 32'h11);

    // R12 auto-execute
    recover();
    wr(8'h21, 32'h0001_0001);
    rd(8'h21, v); check("R12", v, 32'h0001_0001);
    wr(8'h01, 32'h5); check("R12", 32'(busy), 0);
    wr(8'h00, 32'h6); check("R12", 32'(busy), 1);
    recover();
    rd(8'h11, v); check("R12", 32'(busy), 0);
    rd(8'h10, v); check("R12", 32'(busy), 1);
    recover();
    wr(8'h21, 32'h0);

    // R13 program buffer hart port
    wr(8'h10, 32'hcafe_0013);
    rd(8'h10, v); check("R13", v, 32'hcafe_0013);
    @(negedge clk); pb_raddr = 3'd0; @(negedge clk); check("R13", pb_rdata, 32'hcafe_0013);
    @(negedge clk); pb_raddr = 3'd4; @(negedge clk); check("R13", pb_rdata, 32'h0010_0073);

    // random commands
    for (int n = 0; n < 40; n++) begin
      logic [15:0] rg;
      logic [2:0]  sz;
      logic [7:0]  kd;
      logic [31:0] c;
      string lbl;
      case ($urandom % 4)
        0: rg = 16'($urandom % 32'h1000);
        1: rg = 16'h1000 + 16'($urandom % 32);
        2: rg = 16'h1020 + 16'($urandom % 32);
        default: rg = 16'h1040 + 16'($urandom % 256);
      endcase
      sz = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'(2 + $urandom % 2);
      kd = ($urandom % 8 == 0) ? 8'(1 + $urandom % 255) : 8'd0;
      c  = mk(kd, sz, 1'($urandom), 1'($urandom), 1'($urandom), rg);
      if (kd != 0) lbl = "R1";
      else if (c[17] && sz != 3'd2 && sz != 3'd3) lbl = "R6";
      else if (rg < 16'h1000) lbl = "R4";
      else lbl = "R5";
      run_cmd(lbl, c);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule